// File: doc/BRIEF.md
# Serial DAC Input Shift Register

This block is the digital front end of a 14-bit DAC with a three-wire serial input: an active-low select, a serial clock and a data line. All three pins are brought into the system clock domain through two-flop synchronizers. Serial clock rising edges are detected in that domain. While select is low, each detected rising edge shifts one data bit into a 14-bit register, most significant bit first. A 16-bit frame therefore leaves the two leading bits shifted out and keeps only the trailing fourteen.

The holding register that feeds the converter changes only when select returns high after a complete frame. A one-cycle load strobe marks each update. If select returns high before sixteen serial clocks have arrived, the holding register is left unchanged and a short-frame flag is raised. The next complete frame clears that flag.

Control is a four-state machine. ST_IDLE waits while select is high and moves to ST_SHIFT when select is low. ST_SHIFT accepts bits. When select rises it goes to ST_COMMIT if the bit count reached sixteen, and otherwise to ST_ABORT. ST_COMMIT writes the holding register, pulses the strobe and clears the flag. ST_ABORT sets the flag. Both ST_COMMIT and ST_ABORT return to ST_IDLE after one cycle.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, dac_word is 0, word_load is 0 and frame_short is 0.
- R2: A 16-bit frame is sent MSB first. After select rises, dac_word equals bits 13..0 of the frame, and bits 15 and 14 have no effect.
- R3: While select stays low, dac_word keeps its previous value, even after sixteen bits have been shifted in.
- R4: After select rises on a complete frame, word_load is 1 for exactly one system cycle, starting 4 system clock edges after the pin change. dac_word takes its new value on the same edge.
- R5: When more than 16 serial clocks occur in one frame, dac_word receives the 14 most recently shifted bits.
- R6: When select rises after fewer than 16 serial clocks, dac_word is unchanged, word_load stays 0, and frame_short becomes 1 on the edge where a load would otherwise have occurred.
- R7: frame_short stays at 1 until the next complete frame is loaded, and it is 0 from that load onward.
- R8: The bit count and shift register restart for every frame. Serial clocks while select is high shift nothing, and bits from an aborted frame do not count toward the next one.
- R9: Data is sampled only at the serial clock rising edge. Changes on the data line while the serial clock is high do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Serial select pin, active low, asynchronous |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_data | input | 1 | Serial data pin, asynchronous |
| dac_word | output | 14 | Holding register driving the converter |
| word_load | output | 1 | One-cycle strobe on each holding-register update |
| frame_short | output | 1 | Set by an incomplete frame, cleared by a complete one |

## Verification
A pin change passes through two synchronizer flops and then an edge comparison. The state register takes one more edge, and the output register another. A select release therefore shows up on dac_word, word_load and frame_short at the fourth system clock edge after the change. The bench drives pins on falling system edges, waits exactly four rising edges, and samples on the next falling edge. It then samples once more one cycle later to confirm the strobe has dropped. Serial bits are held for four system cycles before each serial clock rise, so the data synchronizer has settled when the shift takes place. Values written by the checks are computed from the frame contents alone.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int FRAME_BITS  = 16;
    localparam int CODE_BITS   = 14;
    localparam int SYNC_STAGES = 2;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_ABORT  = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= INIT;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= INIT;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= INIT;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [CODE_BITS-1:0] code,
    output logic                 full
);
    logic [CODE_BITS-1:0] sr_q;
    logic [CNT_W-1:0]     cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[CODE_BITS-2:0], bit_in};
            if (cnt_q != CNT_W'(FRAME_BITS))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign code = sr_q;
    assign full = (cnt_q == CNT_W'(FRAME_BITS));
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_lvl,
    input  logic                 sclk_rise,
    input  logic                 frame_full,
    input  logic [CODE_BITS-1:0] shift_code,
    output logic                 shift_clear,
    output logic                 shift_en,
    output logic [CODE_BITS-1:0] hold_q,
    output logic                 load_q,
    output logic                 short_q
);
    ctrl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!sel_lvl) state_d = ST_SHIFT;
            ST_SHIFT:  if (sel_lvl)  state_d = frame_full ? ST_COMMIT : ST_ABORT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign shift_clear = (state_q != ST_SHIFT);
    assign shift_en    = (state_q == ST_SHIFT) && sclk_rise && !sel_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            load_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            unique case (state_q)
                ST_COMMIT: begin
                    hold_q  <= shift_code;
                    load_q  <= 1'b1;
                    short_q <= 1'b0;
                end
                ST_ABORT:  short_q <= 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    output logic [CODE_BITS-1:0] dac_word,
    output logic                 word_load,
    output logic                 frame_short
);
    logic [2:0]           pins_s;
    logic                 sel_s, sclk_s, data_s;
    logic                 sclk_rise, sclk_fall;
    logic                 sh_clear, sh_en, sh_full;
    logic [CODE_BITS-1:0] sh_code;

    sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({sel_n, ser_clk, ser_data}),
        .sync_out(pins_s)
    );

    assign sel_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign data_s = pins_s[0];

    sdac_edge #(.INIT(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .level(sclk_s),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    sdac_shift u_shift (
        .clk(clk), .rst_n(rst_n), .clear(sh_clear), .shift_en(sh_en),
        .bit_in(data_s), .code(sh_code), .full(sh_full)
    );

    sdac_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_lvl(sel_s), .sclk_rise(sclk_rise),
        .frame_full(sh_full), .shift_code(sh_code),
        .shift_clear(sh_clear), .shift_en(sh_en),
        .hold_q(dac_word), .load_q(word_load), .short_q(frame_short)
    );

    logic unused_fall;
    assign unused_fall = sclk_fall;
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
    parameter int CODE_BITS = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CODE_BITS-1:0] dac_word,
    input logic                 word_load,
    input logic                 frame_short
);
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |=> !word_load);

    p_word_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_load |-> $stable(dac_word));

    p_load_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> !frame_short);

    p_flag_drops_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_short) |-> word_load);

    p_short_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_short) |-> !word_load);
endmodule

bind sdac_frontend sdac_frontend_chk #(.CODE_BITS(14)) u_chk (
    .clk(clk), .rst_n(rst_n), .dac_word(dac_word),
    .word_load(word_load), .frame_short(frame_short)
);

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [13:0] dac_word;
    logic        word_load;
    logic        frame_short;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [13:0] model_word = '0;

    always #10 clk = ~clk;

    sdac_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .dac_word(dac_word), .word_load(word_load),
        .frame_short(frame_short)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n, input bit wiggle);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = bits[i];
            ser_clk  = 1'b0;
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(2);
            if (wiggle) ser_data = ~bits[i];
            wait_cyc(2);
        end
        ser_clk = 1'b0;
    endtask

    task automatic close_frame(input string req, input bit exp_load,
                               input logic [13:0] exp_word, input bit exp_short);
        sel_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({req, " strobe"}, word_load, exp_load);
        check({req, " word"}, dac_word, exp_word);
        check({req, " flag"}, frame_short, exp_short);
        @(negedge clk);
        check({req, " strobe drop"}, word_load, 1'b0);
        wait_cyc(4);
    endtask

    task automatic run_frame(input string req, input logic [31:0] bits, input int n,
                             input bit wiggle, input bit exp_short_after);
        bit full;
        full = (n >= 16);
        @(negedge clk);
        sel_n = 1'b0;
        wait_cyc(4);
        send_bits(bits, n, wiggle);
        wait_cyc(6);
        check({req, " R3 held while selected"}, dac_word, model_word);
        if (full) model_word = bits[13:0];
        close_frame(req, full, model_word, exp_short_after);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1 word", dac_word, 14'h0);
        check("R1 strobe", word_load, 1'b0);
        check("R1 flag", frame_short, 1'b0);
    endtask

    task automatic t_basic();
        run_frame("R2 R4 frame E5A3", 32'hE5A3, 16, 1'b0, 1'b0);
        run_frame("R2 frame 3FFF", 32'h3FFF, 16, 1'b0, 1'b0);
        run_frame("R2 frame 8001", 32'h8001, 16, 1'b0, 1'b0);
    endtask

    task automatic t_long();
        run_frame("R5 20 clocks", 32'hABCDE, 20, 1'b0, 1'b0);
        check("R5 last fourteen", dac_word, 14'h3CDE);
    endtask

    task automatic t_short();
        run_frame("R6 10 clocks", 32'h155, 10, 1'b0, 1'b1);
        run_frame("R8 R6 restart 6 clocks", 32'h2A, 6, 1'b0, 1'b1);
        run_frame("R7 R8 full frame clears flag", 32'h4321, 16, 1'b0, 1'b0);
    endtask

    task automatic t_idle_clocks();
        @(negedge clk);
        send_bits(32'hFF, 8, 1'b0);
        wait_cyc(6);
        check("R8 idle clocks no strobe", word_load, 1'b0);
        check("R8 idle clocks word", dac_word, model_word);
        run_frame("R8 frame after idle clocks", 32'h0000, 16, 1'b0, 1'b0);
    endtask

    task automatic t_wiggle();
        run_frame("R9 data changes while high", 32'h96C3, 16, 1'b1, 1'b0);
        check("R9 sampled at rise", dac_word, 14'h16C3);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_long();
        t_short();
        t_idle_clocks();
        t_wiggle();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end
endmodule